// File: doc/BRIEF.md
# Audio Sample Rate Mode Detector

This block watches an incoming left/right frame clock, whose frequency equals the audio sample rate. It counts reference-clock cycles between consecutive rising edges of that clock and sorts each measured period into one of three speed bands. Quad speed covers 120 kHz to 216 kHz, double speed covers 60 kHz to 108 kHz and single speed covers 30 kHz to 54 kHz. A period that lands in no band, or a frame clock that stops, raises an out-of-range flag. The last valid speed is held while the flag is raised. The block also reports the master-clock multiplier that belongs to the reported speed.

A 2-bit functional-mode input selects between automatic detection and a forced speed. The input is honoured only in control mode. When the stand-alone strap is high, detection is always automatic and the functional-mode input is ignored. Band limits are derived from the reference frequency parameter, so the same block serves any reference clock.

Detection runs in a tracking state machine with three states:
- `TRK_ARM` waits for the first frame edge after reset or after a timeout.
- `TRK_FIRST` times the first full period.
- `TRK_TRACK` times each further period and compares its band with the band of the period before it.

The transitions are:
- `ARM_TO_FIRST`: on a rising frame edge in `TRK_ARM`.
- `FIRST_TO_TRACK`: on the next rising frame edge.
- `TRACK_STAY`: on every later rising frame edge.
- `ANY_TIMEOUT`: from any state back to `TRK_ARM` when the period counter saturates. This transition has priority over an edge in the same cycle.

Top module: `fs_mode_detect`

## Requirements
- R1: After reset, `speed_o` is 00 (no speed yet), `out_of_range_o` is 0, `mclk_mult_o` is 0, and automatic detection is active.
- R2: In automatic detection, a frame rate from 30 kHz to 54 kHz is reported as single speed, `speed_o` = 01.
- R3: In automatic detection, a frame rate from 60 kHz to 108 kHz is reported as double speed, `speed_o` = 10.
- R4: In automatic detection, a frame rate from 120 kHz to 216 kHz is reported as quad speed, `speed_o` = 11.
- R5: The reported speed changes only when two consecutive period measurements fall in the same band. Periods that alternate between bands leave the speed unchanged.
- R6: Two consecutive periods that fall in no band (faster than 216 kHz, or in a gap between bands) set `out_of_range_o` to 1 and keep the last valid speed.
- R7: If no rising frame edge arrives within the longest single-speed period, `out_of_range_o` goes to 1 and the last valid speed is kept.
- R8: With the stand-alone strap low and `fmode_i` not 00, `speed_o` equals `fmode_i` (01 single, 10 double, 11 quad) and `out_of_range_o` is 0. Setting `fmode_i` back to 00 restores the automatic result.
- R9: With the stand-alone strap high, `fmode_i` has no effect and the automatic result is reported.
- R10: `mclk_mult_o` is 256 for single and double speed, 128 for quad speed, and 0 while no speed has been established.
- R11: Two consecutive in-band periods that agree clear `out_of_range_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Asynchronous left/right frame clock |
| standalone_i | input | 1 | Strap: 1 = stand-alone, detection forced on |
| fmode_i | input | 2 | Functional mode: 00 auto, 01 single, 10 double, 11 quad |
| speed_o | output | 2 | Reported speed: 00 none, 01 single, 10 double, 11 quad |
| out_of_range_o | output | 1 | Frame rate unsupported or frame clock missing |
| mclk_mult_o | output | 9 | Master-clock multiplier for the reported speed |

## Verification
The assertions take the following for granted:
- Every high and low phase of the frame clock lasts more reference cycles than the synchronizer depth, so each rising edge produces exactly one edge pulse.
- The strap and the functional-mode inputs change synchronously to the reference clock.

The stimulus keeps within these limits. It drives the frame clock and the mode inputs only on falling reference edges, with whole-cycle phases of at least six cycles. It scales the reference frequency parameter so that every band, every gap and the timeout are reached in a few hundred cycles per period.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic [1:0] {
        SPD_NONE   = 2'b00,
        SPD_SINGLE = 2'b01,
        SPD_DOUBLE = 2'b10,
        SPD_QUAD   = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        TRK_ARM   = 2'b00,
        TRK_FIRST = 2'b01,
        TRK_TRACK = 2'b10
    } trk_state_e;

    localparam int MULT_W = 9;
endpackage

// File: rtl/fsd_edge_sync.sv
module fsd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsd_period_ctr.sv
module fsd_period_ctr #(
    parameter int LIMIT = 820,
    parameter int W     = $clog2(LIMIT + 2)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         rise_i,
    output logic [W-1:0] period_o,
    output logic         timeout_o
);
    localparam logic [W-1:0] LIM_C = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (rise_i)     cnt_q <= '0;
        else if (!timeout_o) cnt_q <= cnt_q + 1'b1;
    end

    // Saturated count marks a frame clock slower than the slowest band.
    assign timeout_o = (cnt_q >= LIM_C);
    assign period_o  = cnt_q + 1'b1;

    AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM_C); // R7
endmodule

// File: rtl/fsd_band_classify.sv
module fsd_band_classify
    import fsd_pkg::*;
#(
    parameter int W     = 10,
    parameter int QS_LO = 113,
    parameter int QS_HI = 205,
    parameter int DS_LO = 227,
    parameter int DS_HI = 410,
    parameter int SS_LO = 455,
    parameter int SS_HI = 820
) (
    input  logic [W-1:0] period_i,
    output speed_e       band_o
);
    localparam logic [W-1:0] QS_LO_C = W'(QS_LO);
    localparam logic [W-1:0] QS_HI_C = W'(QS_HI);
    localparam logic [W-1:0] DS_LO_C = W'(DS_LO);
    localparam logic [W-1:0] DS_HI_C = W'(DS_HI);
    localparam logic [W-1:0] SS_LO_C = W'(SS_LO);
    localparam logic [W-1:0] SS_HI_C = W'(SS_HI);

    always_comb begin
        if (period_i >= QS_LO_C && period_i <= QS_HI_C)      band_o = SPD_QUAD;
        else if (period_i >= DS_LO_C && period_i <= DS_HI_C) band_o = SPD_DOUBLE;
        else if (period_i >= SS_LO_C && period_i <= SS_HI_C) band_o = SPD_SINGLE;
        else                                                 band_o = SPD_NONE;
    end
endmodule

// File: rtl/fsd_track_fsm.sv
module fsd_track_fsm
    import fsd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   rise_i,
    input  logic   timeout_i,
    input  speed_e band_i,
    output speed_e mode_o,
    output logic   oor_o
);
    trk_state_e state_q, state_d;
    speed_e     cand_q, mode_q;
    logic       oor_q;

    // Next state: timeout wins over an edge in the same cycle.
    always_comb begin
        state_d = state_q;
        if (timeout_i) begin
            state_d = TRK_ARM;                      // ANY_TIMEOUT
        end else if (rise_i) begin
            unique case (state_q)
                TRK_ARM:   state_d = TRK_FIRST;     // ARM_TO_FIRST
                TRK_FIRST: state_d = TRK_TRACK;     // FIRST_TO_TRACK
                TRK_TRACK: state_d = TRK_TRACK;     // TRACK_STAY
                default:   state_d = TRK_ARM;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TRK_ARM;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cand_q <= SPD_NONE;
            mode_q <= SPD_NONE;
            oor_q  <= 1'b0;
        end else if (timeout_i) begin
            oor_q <= 1'b1;
        end else if (rise_i) begin
            unique case (state_q)
                TRK_ARM: begin
                end
                TRK_FIRST: cand_q <= band_i;
                TRK_TRACK: begin
                    cand_q <= band_i;
                    if (band_i == cand_q) begin
                        if (band_i == SPD_NONE) begin
                            oor_q <= 1'b1;
                        end else begin
                            mode_q <= band_i;
                            oor_q  <= 1'b0;
                        end
                    end
                end
                default: cand_q <= SPD_NONE;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign oor_o  = oor_q;

    AST_MODE_ONLY_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rise_i && !timeout_i) |=> ($stable(mode_q) && $stable(oor_q))); // R5
    AST_TIMEOUT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_i |=> oor_q); // R7
    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q != SPD_NONE) |=> (mode_q != SPD_NONE)); // R6
endmodule

// File: rtl/fs_mode_detect.sv
module fs_mode_detect
    import fsd_pkg::*;
#(
    parameter int REF_HZ      = 24_576_000,
    parameter int SS_MIN_HZ   = 30_000,
    parameter int SS_MAX_HZ   = 54_000,
    parameter int DS_MIN_HZ   = 60_000,
    parameter int DS_MAX_HZ   = 108_000,
    parameter int QS_MIN_HZ   = 120_000,
    parameter int QS_MAX_HZ   = 216_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_clk_i,
    input  logic              standalone_i,
    input  logic [1:0]        fmode_i,
    output logic [1:0]        speed_o,
    output logic              out_of_range_o,
    output logic [MULT_W-1:0] mclk_mult_o
);
    // Period limits in reference cycles: floor for short, ceiling for long.
    localparam int QS_LO = REF_HZ / QS_MAX_HZ;
    localparam int QS_HI = (REF_HZ + QS_MIN_HZ - 1) / QS_MIN_HZ;
    localparam int DS_LO = REF_HZ / DS_MAX_HZ;
    localparam int DS_HI = (REF_HZ + DS_MIN_HZ - 1) / DS_MIN_HZ;
    localparam int SS_LO = REF_HZ / SS_MAX_HZ;
    localparam int SS_HI = (REF_HZ + SS_MIN_HZ - 1) / SS_MIN_HZ;
    localparam int CNT_W = $clog2(SS_HI + 2);

    logic             rise;
    logic             timeout;
    logic [CNT_W-1:0] period;
    speed_e           band;
    speed_e           auto_mode;
    logic             auto_oor;
    speed_e           sel_speed;
    logic             sel_oor;
    logic [MULT_W-1:0] sel_mult;

    fsd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (frame_clk_i),
        .rise_o  (rise)
    );

    fsd_period_ctr #(.LIMIT(SS_HI), .W(CNT_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .period_o  (period),
        .timeout_o (timeout)
    );

    fsd_band_classify #(
        .W(CNT_W), .QS_LO(QS_LO), .QS_HI(QS_HI), .DS_LO(DS_LO),
        .DS_HI(DS_HI), .SS_LO(SS_LO), .SS_HI(SS_HI)
    ) u_cls (
        .period_i (period),
        .band_o   (band)
    );

    fsd_track_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .timeout_i (timeout),
        .band_i    (band),
        .mode_o    (auto_mode),
        .oor_o     (auto_oor)
    );

    // Override only in control mode; auto when strapped or field is 00.
    always_comb begin
        if (standalone_i || fmode_i == 2'b00) begin
            sel_speed = auto_mode;
            sel_oor   = auto_oor;
        end else begin
            sel_speed = speed_e'(fmode_i);
            sel_oor   = 1'b0;
        end
        unique case (sel_speed)
            SPD_NONE: sel_mult = MULT_W'(0);
            SPD_QUAD: sel_mult = MULT_W'(128);
            default:  sel_mult = MULT_W'(256);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            speed_o        <= 2'b00;
            out_of_range_o <= 1'b0;
            mclk_mult_o    <= '0;
        end else begin
            speed_o        <= sel_speed;
            out_of_range_o <= sel_oor;
            mclk_mult_o    <= sel_mult;
        end
    end

    AST_FORCED_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!standalone_i && fmode_i != 2'b00) |=> (speed_o == $past(fmode_i) && !out_of_range_o)); // R8
    AST_STRAP_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standalone_i |=> (speed_o == $past(auto_mode) && out_of_range_o == $past(auto_oor))); // R9
    AST_QUAD_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (speed_o == 2'b11) |-> (mclk_mult_o == 9'd128)); // R10
    AST_LOW_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (speed_o == 2'b01 || speed_o == 2'b10) |-> (mclk_mult_o == 9'd256)); // R10
endmodule

// File: tb/tb_fs_mode_detect.sv
module tb_fs_mode_detect;
    // Scaled reference: 4 MHz gives quad 18..34, double 37..67, single 74..134 cycles.
    localparam int REF_HZ = 4_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       standalone = 1'b0;
    logic [1:0] fmode = 2'b00;
    logic [1:0] speed;
    logic       oor;
    logic [8:0] mult;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] spd;
        logic       oor;
        logic [8:0] mult;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    fs_mode_detect #(.REF_HZ(REF_HZ)) dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .frame_clk_i    (frame_clk),
        .standalone_i   (standalone),
        .fmode_i        (fmode),
        .speed_o        (speed),
        .out_of_range_o (oor),
        .mclk_mult_o    (mult)
    );

    task automatic expect_out(input logic [1:0] s, input logic o, input logic [8:0] m, input string tag);
        exp_t e;
        e.spd = s; e.oor = o; e.mult = m; e.tag = tag;
        exp_q.push_back(e);
        ->sample_ev;
        #0;
    endtask

    task automatic run_frames(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            frame_clk = 1'b1;
            repeat (p / 2) @(negedge clk);
            frame_clk = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        frame_clk = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (speed !== e.spd || oor !== e.oor || mult !== e.mult) begin
                    errors++;
                    $display("FAIL %s: speed=%0d oor=%0d mult=%0d expected speed=%0d oor=%0d mult=%0d",
                             e.tag, speed, oor, mult, e.spd, e.oor, e.mult);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(2'b00, 1'b0, 9'd0, "R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_out(2'b00, 1'b0, 9'd0, "R1 after reset release");

        run_frames(100, 5);
        expect_out(2'b01, 1'b0, 9'd256, "R2 single speed / R10 mult 256");
        run_frames(50, 5);
        expect_out(2'b10, 1'b0, 9'd256, "R3 double speed / R10 mult 256");
        run_frames(25, 5);
        expect_out(2'b11, 1'b0, 9'd128, "R4 quad speed / R10 mult 128");

        run_frames(100, 5);
        expect_out(2'b01, 1'b0, 9'd256, "R2 single relock");
        for (int k = 0; k < 4; k++) begin
            run_frames(25, 1);
            run_frames(50, 1);
        end
        expect_out(2'b01, 1'b0, 9'd256, "R5 alternating bands keep speed");

        run_frames(12, 6);
        expect_out(2'b01, 1'b1, 9'd256, "R6 too fast flags and holds");
        run_frames(50, 5);
        expect_out(2'b10, 1'b0, 9'd256, "R11 recovery clears flag");
        run_frames(70, 5);
        expect_out(2'b10, 1'b1, 9'd256, "R6 gap rate flags and holds");
        run_frames(25, 5);
        expect_out(2'b11, 1'b0, 9'd128, "R11 quad recovery");

        idle(200);
        expect_out(2'b11, 1'b1, 9'd128, "R7 stopped clock timeout");
        run_frames(150, 4);
        expect_out(2'b11, 1'b1, 9'd128, "R7 too slow times out");

        run_frames(50, 5);
        fmode = 2'b11;
        repeat (2) @(negedge clk);
        expect_out(2'b11, 1'b0, 9'd128, "R8 forced quad");
        fmode = 2'b01;
        repeat (2) @(negedge clk);
        expect_out(2'b01, 1'b0, 9'd256, "R8 forced single");
        fmode = 2'b10;
        idle(200);
        expect_out(2'b10, 1'b0, 9'd256, "R8 forced mode hides flag");
        fmode = 2'b00;
        repeat (2) @(negedge clk);
        expect_out(2'b10, 1'b1, 9'd256, "R8 release to auto");

        standalone = 1'b1;
        fmode = 2'b11;
        run_frames(100, 5);
        expect_out(2'b01, 1'b0, 9'd256, "R9 strap ignores forced quad");
        fmode = 2'b10;
        run_frames(100, 2);
        expect_out(2'b01, 1'b0, 9'd256, "R9 strap ignores forced double");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule